// File: doc/BRIEF.md
# Extended Interrupt Cause and Mask Controller

This unit collects interrupt causes for a network controller and signals them to the host. A 32-bit cause register is set by hardware event pulses, by software through a cause-set register, and by four general-purpose input pins that feed cause bits 24 to 27. Software clears cause bits by writing ones to the cause register. A mask register is written through a separate set port and a separate clear port. An auto-mask register names the mask bits that the hardware clears by itself.

The unit has two signalling modes. In level mode a single interrupt output is high while any cause bit is set and unmasked. In message mode each cause is tied to a vector (cause index modulo the vector count). The lowest-numbered vector that has an active unmasked cause and no pending message is requested, together with its index. That vector's pending bit stays set until the request is acknowledged.

Two control bits set the auto-mask and pending-array behaviour. Bit 30 selects whether the auto-mask acts when a message is issued or when software accesses a cause register. Bit 31 makes mask-set writes clear the pending bits of the matching vectors.

Top module: `irq_cause_ctrl`

Register map (3-bit word address):
- 0 is the cause register. A read returns the causes. A write of 1 clears that bit.
- 1 is cause-set. A write of 1 sets that bit. A read returns the causes.
- 2 is mask-set. A write of 1 sets that mask bit. A read returns the mask.
- 3 is mask-clear. A write of 1 clears that mask bit. A read returns the mask.
- 4 is the auto-mask register, read and write.
- 5 is control, read and write. Bit 0 selects message mode. Bits 11:8 are the pin directions, where 1 means input. Bits 19:16 are the pin enables. Bit 30 selects auto-mask on message issue. Bit 31 selects pending-array support. All other bits read 0.
- 6 returns the pending bits in its low bits. It is read-only.

## Requirements
- R1: After reset the cause, mask, auto-mask, control and pending registers read 0, and irq_o and msg_req_o are low.
- R2: Writing 1s to address 1 sets those cause bits. Writing 1s to address 0 clears them. A hardware event pulse on hw_evt_i sets the matching cause bits.
- R3: Writing 1s to address 2 sets mask bits. Writing 1s to address 3 clears them.
- R4: In level mode (control bit 0 = 0), irq_o equals the OR of cause AND mask. In message mode irq_o stays low.
- R5: Pin k sets cause bit 24+k on the third clock edge after it is driven high. This happens only when direction bit 8+k and enable bit 16+k are both 1. Any other pin has no effect.
- R6: In message mode a request is raised one edge after a cause becomes active. It targets the lowest vector with an active unmasked cause and a clear pending bit, where cause i belongs to vector i mod NVEC. That vector's pending bit is set. The request and its index hold until msg_ack_i.
- R7: An acknowledge clears the request and the acknowledged vector's pending bit.
- R8: With control bit 30 set, an acknowledge clears those mask bits that are set in the auto-mask and belong to the acknowledged vector. Cause register accesses then leave the mask unchanged.
- R9: With control bit 30 clear, any read or write of address 0 or 1 clears the mask bits set in the auto-mask. Accesses to other addresses do not.
- R10: With control bit 31 set, writing 1 to mask-set bit i clears the pending bit of vector i mod NVEC. With bit 31 clear the pending bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (marks a read access) |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| hw_evt_i | input | 32 | Hardware cause pulses |
| pin_i | input | 4 | Asynchronous general-purpose pins |
| irq_o | output | 1 | Level interrupt |
| msg_req_o | output | 1 | Message request |
| msg_vec_o | output | VW | Requested vector index |
| msg_ack_i | input | 1 | Message acknowledge |

## Verification
The bench builds the unit with the default of four vectors. Causes 1 and 5 therefore share vector 1, and causes 2 and 7 fall on vectors 2 and 3. This makes it possible to check lowest-vector selection, pending bits set and cleared per vector, and an auto-mask that clears only the acknowledged vector's own causes. A random level-mode phase mixes set, clear and mask writes with hardware pulses against a bench model. Directed runs cover the pin gating and the synchronizer delay, as well as both settings of control bits 30 and 31.

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
  parameter int NVEC = 4,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [31:0]   hw_evt_i,
  input  logic [3:0]    pin_i,
  output logic          irq_o,
  output logic          msg_req_o,
  output logic [VW-1:0] msg_vec_o,
  input  logic          msg_ack_i
);
  localparam logic [31:0] CTRL_BITS = 32'hC00F_0F01;
  localparam int PIN_BASE = 24;

  logic [31:0] cause_q, mask_q, amask_q, ctrl_q;
  logic [NVEC-1:0] pend_q, pend_d, act, cand, pba_clr;
  logic [NVEC-1:0][31:0] vmap;
  logic [3:0] s1_q, s2_q, gpi;
  logic req_q, issue, ack_fire, cause_acc;
  logic [VW-1:0] vec_q, pick;
  logic [31:0] w1c, cset, mset, mclr, am_clr;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    for (genvar i = 0; i < 32; i++) begin : g_bit
      assign vmap[v][i] = ((i % NVEC) == v);
    end
    assign act[v]     = |(cause_q & mask_q & vmap[v]);
    assign pba_clr[v] = |(mset & vmap[v]);
  end

  assign cand = act & ~pend_q;

  always_comb begin
    pick = '0;
    for (int v = NVEC - 1; v >= 0; v--)
      if (cand[v]) pick = VW'(v);
  end

  assign w1c  = (wr_en_i && addr_i == 3'd0) ? wdata_i : '0;
  assign cset = (wr_en_i && addr_i == 3'd1) ? wdata_i : '0;
  assign mset = (wr_en_i && addr_i == 3'd2) ? wdata_i : '0;
  assign mclr = (wr_en_i && addr_i == 3'd3) ? wdata_i : '0;
  assign cause_acc = (wr_en_i || rd_en_i) && (addr_i == 3'd0 || addr_i == 3'd1);
  assign ack_fire = req_q && msg_ack_i;
  assign issue = ctrl_q[0] && !req_q && (|cand);
  assign gpi = s2_q & ctrl_q[11:8] & ctrl_q[19:16];

  assign am_clr = ((cause_acc && !ctrl_q[30]) ? amask_q : '0)
                | ((ack_fire && ctrl_q[30]) ? (amask_q & vmap[vec_q]) : '0);

  always_comb begin
    pend_d = pend_q;
    if (ctrl_q[31]) pend_d = pend_d & ~pba_clr;
    if (ack_fire) pend_d[vec_q] = 1'b0;
    if (issue) pend_d[pick] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
      amask_q <= '0;
      ctrl_q  <= '0;
      pend_q  <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
      req_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      s1_q    <= pin_i;
      s2_q    <= s1_q;
      cause_q <= (cause_q & ~w1c) | cset | hw_evt_i | (32'(gpi) << PIN_BASE);
      mask_q  <= (mask_q | mset) & ~mclr & ~am_clr;
      if (wr_en_i && addr_i == 3'd4) amask_q <= wdata_i;
      if (wr_en_i && addr_i == 3'd5) ctrl_q <= wdata_i & CTRL_BITS;
      pend_q  <= pend_d;
      if (ack_fire) req_q <= 1'b0;
      else if (issue) begin
        req_q <= 1'b1;
        vec_q <= pick;
      end
    end
  end

  always_comb begin
    case (addr_i)
      3'd0, 3'd1: rdata_o = cause_q;
      3'd2, 3'd3: rdata_o = mask_q;
      3'd4:       rdata_o = amask_q;
      3'd5:       rdata_o = ctrl_q;
      3'd6:       rdata_o = 32'(pend_q);
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o     = !ctrl_q[0] && (|(cause_q & mask_q));
  assign msg_req_o = req_q;
  assign msg_vec_o = vec_q;
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
  parameter int NVEC = 4,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [2:0]    addr_i,
  input logic [31:0]   wdata_i,
  input logic [31:0]   cause_q,
  input logic [31:0]   mask_q,
  input logic [NVEC-1:0] pend_q,
  input logic          msg_req_o,
  input logic [VW-1:0] msg_vec_o,
  input logic          msg_ack_i
);
  // R2
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd1) |=> ((cause_q & $past(wdata_i)) == $past(wdata_i)));

  // R3
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd3) |=> ((mask_q & $past(wdata_i)) == 32'd0));

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_req_o && !msg_ack_i) |=> (msg_req_o && $stable(msg_vec_o)));

  // R6
  req_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_req_o) |-> pend_q[msg_vec_o]);

  // R7
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_req_o && msg_ack_i) |=> (!msg_req_o && !pend_q[$past(msg_vec_o)]));
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.NVEC(NVEC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .cause_q(cause_q), .mask_q(mask_q), .pend_q(pend_q),
  .msg_req_o(msg_req_o), .msg_vec_o(msg_vec_o), .msg_ack_i(msg_ack_i)
);

// File: tb/test_irq_cause_ctrl.sv
module test_irq_cause_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata, evt = '0;
  logic [3:0] pins = '0;
  logic irq, req;
  logic [1:0] vec;
  int n_chk = 0, n_fail = 0;
  logic [31:0] m_cause = '0, m_mask = '0;

  always #5 clk = ~clk;

  irq_cause_ctrl #(.NVEC(4)) i_irq_cause_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .hw_evt_i(evt),
    .pin_i(pins), .irq_o(irq), .msg_req_o(req), .msg_vec_o(vec),
    .msg_ack_i(ack));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 3'd7;
  endtask

  task automatic rd_access(logic [2:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; addr = 3'd7;
  endtask

  task automatic peek(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = 3'd7;
  endtask

  task automatic pulse_evt(logic [31:0] d);
    @(negedge clk); evt = d;
    @(negedge clk); evt = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  function automatic logic level_irq(logic [31:0] c, logic [31:0] m);
    return |(c & m);
  endfunction

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    addr = 3'd7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(3'd0, d); check("R1 cause", d, 0);
    peek(3'd2, d); check("R1 mask", d, 0);
    peek(3'd4, d); check("R1 automask", d, 0);
    peek(3'd5, d); check("R1 ctrl", d, 0);
    peek(3'd6, d); check("R1 pend", d, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 req", 32'(req), 0);

    for (int it = 0; it < 60; it++) begin
      int op = $urandom_range(0, 4);
      logic [31:0] r = $urandom & $urandom;
      case (op)
        0: begin wr(3'd0, r); m_cause &= ~r; end
        1: begin wr(3'd1, r); m_cause |= r; end
        2: begin wr(3'd2, r); m_mask |= r; end
        3: begin wr(3'd3, r); m_mask &= ~r; end
        default: begin pulse_evt(r); m_cause |= r; end
      endcase
      peek(3'd1, d); check("R2 cause model", d, m_cause);
      peek(3'd3, d); check("R3 mask model", d, m_mask);
      check("R4 level irq", 32'(irq), 32'(level_irq(m_cause, m_mask)));
    end
    wr(3'd1, 32'h0000_0010); wr(3'd2, 32'h0000_0010);
    check("R4 irq high", 32'(irq), 1);
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd0, 32'hFFFF_FFFF);
    check("R4 irq low", 32'(irq), 0);

    // R5 pins: pin2 enabled input; pin1 input not enabled; pin3 enabled not input
    wr(3'd5, (32'h4 << 8) | (32'h4 << 16) | (32'h2 << 8) | (32'h8 << 16));
    @(negedge clk); pins = 4'b1110;
    @(negedge clk); @(negedge clk);
    peek(3'd0, d); check("R5 pin not yet", d, 0);
    @(negedge clk);
    peek(3'd0, d); check("R5 pin cause", d, 32'h0400_0000);
    pins = 4'b0000;
    repeat (3) @(negedge clk);
    wr(3'd0, 32'hFFFF_FFFF);
    peek(3'd0, d); check("R5 pin cleared", d, 0);

    // R9 automask on cause access in level mode
    wr(3'd5, 32'h0);
    wr(3'd4, 32'h0000_00F0);
    wr(3'd2, 32'h0000_00FF);
    rd_access(3'd0);
    peek(3'd2, d); check("R9 read cause", d, 32'h0000_000F);
    wr(3'd2, 32'h0000_00F0);
    wr(3'd1, 32'h0);
    peek(3'd2, d); check("R9 write cset", d, 32'h0000_000F);
    wr(3'd2, 32'h0000_00F0);
    rd_access(3'd4);
    peek(3'd2, d); check("R9 other addr", d, 32'h0000_00FF);
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'h0);

    // R6 message mode, lowest vector first
    wr(3'd5, 32'h1);
    wr(3'd2, 32'h0000_00A4);
    wr(3'd1, 32'h0000_00A4);
    check("R6 no req yet", 32'(req), 0);
    @(negedge clk);
    check("R6 req", 32'(req), 1);
    check("R6 vec1", 32'(vec), 1);
    peek(3'd6, d); check("R6 pend", d, 32'h2);
    check("R4 msg irq low", 32'(irq), 0);
    wr(3'd0, 32'h0000_0020);
    check("R6 hold", {30'd0, vec} | (32'(req) << 4), 32'h11);
    do_ack();
    check("R7 req cleared", 32'(req), 0);
    peek(3'd6, d); check("R7 pend cleared", d, 0);
    @(negedge clk);
    check("R6 next vec2", {30'd0, vec} | (32'(req) << 4), 32'h12);
    peek(3'd6, d); check("R6 pend2", d, 32'h4);
    wr(3'd0, 32'hFFFF_FFFF);
    do_ack();
    @(negedge clk);
    check("R7 idle", 32'(req), 0);

    // R10 pending clear on mask-set
    wr(3'd5, 32'h8000_0001);
    wr(3'd1, 32'h0000_0020);
    @(negedge clk);
    peek(3'd6, d); check("R10 pend set", d, 32'h2);
    wr(3'd2, 32'h0000_0002);
    peek(3'd6, d); check("R10 pend cleared", d, 0);
    wr(3'd0, 32'hFFFF_FFFF); do_ack(); @(negedge clk);
    wr(3'd5, 32'h0000_0001);
    wr(3'd1, 32'h0000_0020);
    @(negedge clk);
    wr(3'd2, 32'h0000_0002);
    peek(3'd6, d); check("R10 legacy keeps pend", d, 32'h2);
    wr(3'd0, 32'hFFFF_FFFF); do_ack(); @(negedge clk);

    // R8 automask on message acknowledge
    wr(3'd5, 32'h4000_0001);
    wr(3'd4, 32'h0000_0020);
    peek(3'd2, d); check("R8 mask before", d, 32'h0000_00A6);
    wr(3'd1, 32'h0000_0020);
    @(negedge clk);
    check("R8 req vec1", {30'd0, vec} | (32'(req) << 4), 32'h11);
    peek(3'd2, d); check("R8 no clear on issue", d, 32'h0000_00A6);
    do_ack();
    peek(3'd2, d); check("R8 ack clears", d, 32'h0000_0086);
    @(negedge clk);
    check("R8 no rerequest", 32'(req), 0);
    wr(3'd4, 32'h0000_0080);
    wr(3'd0, 32'hFFFF_FFFF);
    peek(3'd2, d); check("R8 access no clear", d, 32'h0000_0086);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule